// File: doc/BRIEF.md
# AXI4-Lite GCD Accelerator

This block is a memory-mapped coprocessor that finds the greatest common divisor of two 32-bit unsigned numbers. A processor reaches it through an AXI4-Lite slave port with 32-bit address and data. Software loads the two operands, sets a launch bit in the control word and then either waits a known number of cycles or polls a done flag in the same word. When the flag is up, it reads the result register.

Inside, two independent channel handlers carry the write path (address, data, response) and the read path (address, data). Each transfer follows the valid/ready rule: a beat moves only on a rising clock edge where both valid and ready are high. A master that sees ready low keeps valid and its payload steady. The slave applies back-pressure on a new address while that channel still holds an unreturned response. The write address and write data may arrive in either order or together. The response is raised only once both have been taken. The arithmetic is done by an iterative engine that subtracts the smaller working value from the larger until the two are equal or one is zero.

Word map, by byte offset: 0x00 control/status, 0x04 operand A, 0x08 operand B, 0x0C result. An offset is mapped only if it is word aligned and below 0x10.

Top module: `gcd_axil_accel`

## Requirements
- R1: While aresetn is low on a clock edge, the block clears the operands, the result, the control bits and the channel state. After reset, BVALID and RVALID are 0, AWREADY, WREADY and ARREADY are 1, and all four mapped words read 0.
- R2: Operand A at 0x04 and operand B at 0x08 read back what was written. Each byte lane is written only when its WSTRB bit is set, with lane i being data bits 8i+7..8i.
- R3: Writing a word with bit 0 set (lane 0 strobed) to 0x00 launches a computation on the current A and B. Bit 0 of 0x00 reads 0 again by the time the write response has been taken. Bit 1 of 0x00 reads 1 once the result at 0x0C is valid. gcd(35,25)=5 and gcd(128,72)=8 are both readable within 20 cycles of the launching write.
- R4: An accepted launch clears bit 1 of 0x00 until that computation ends.
- R5: If either operand is 0, the result is the other operand (gcd(0,0)=0), and it finishes one cycle after the launch is taken.
- R6: The write address and the write data are each accepted on their own handshake, in either order or in the same cycle. BVALID rises only after both have been accepted. BRESP and RRESP are always 00 (OKAY).
- R7: An unmapped offset (unaligned, or 0x10 and above) reads as 0, and a write to it changes no register.
- R8: BVALID holds until BREADY is seen, and RVALID holds with RDATA unchanged until RREADY is seen. While a write response is pending, AWREADY and WREADY stay 0. While a read response is pending, ARREADY stays 0.
- R9: Writes to A or B during a computation are stored but do not alter the running result. A launch written during a computation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock, rising edge |
| aresetn | input | 1 | Synchronous reset, active low |
| s_axil_awaddr | input | 32 | Write address (byte offset) |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | 32 | Write data |
| s_axil_wstrb | input | 4 | Write byte strobes |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response, always OKAY |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | 32 | Read address (byte offset) |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | 32 | Read data |
| s_axil_rresp | output | 2 | Read response, always OKAY |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |

## Verification
A stuck launch or done flag shows up on the very next read of the control word. A wrong value in the engine's working pair shows up as a wrong result when the flag rises, a few to a hundred cycles after launch depending on the operands. A half-held write address or data beat shows up within one cycle: BVALID rises early, or it never rises and the bench's wait stalls. The runs are chosen so that each such fault changes a value read back through the port: a launch that disturbs a running computation changes the result from 10 to 1, and a strobe fault changes a single byte of an operand.

// File: rtl/gcd_axil_pkg.sv
package gcd_axil_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  // word index inside the four-word window (byte offset >> 2)
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_OPA  = 2'd1;
  localparam logic [1:0] IDX_OPB  = 2'd2;
  localparam logic [1:0] IDX_RES  = 2'd3;

  localparam int CTRL_LAUNCH_BIT = 0;
  localparam int CTRL_DONE_BIT   = 1;

  typedef enum logic { ENG_IDLE, ENG_RUN } eng_state_t;
endpackage

// File: rtl/gcd_axil_wport.sv
module gcd_axil_wport #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  output logic              cmt_en,
  output logic [ADDR_W-1:0] cmt_addr,
  output logic [DATA_W-1:0] cmt_data,
  output logic [STRB_W-1:0] cmt_strb
);
  logic              aw_held, w_held, bvalid_q;
  logic [ADDR_W-1:0] aw_q;
  logic [DATA_W-1:0] wd_q;
  logic [STRB_W-1:0] ws_q;
  logic              aw_fire, w_fire;

  assign awready = !aw_held && !bvalid_q;
  assign wready  = !w_held && !bvalid_q;
  assign aw_fire = awvalid && awready;
  assign w_fire  = wvalid && wready;
  assign bvalid  = bvalid_q;

  // a write commits on the cycle the second of its two beats lands
  assign cmt_en   = (aw_held || aw_fire) && (w_held || w_fire);
  assign cmt_addr = aw_held ? aw_q : awaddr;
  assign cmt_data = w_held ? wd_q : wdata;
  assign cmt_strb = w_held ? ws_q : wstrb;

  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      aw_held  <= 1'b0;
      w_held   <= 1'b0;
      bvalid_q <= 1'b0;
      aw_q     <= '0;
      wd_q     <= '0;
      ws_q     <= '0;
    end else begin
      if (aw_fire) aw_q <= awaddr;
      if (w_fire) begin
        wd_q <= wdata;
        ws_q <= wstrb;
      end
      if (cmt_en) begin
        aw_held  <= 1'b0;
        w_held   <= 1'b0;
        bvalid_q <= 1'b1;
      end else begin
        if (aw_fire) aw_held <= 1'b1;
        if (w_fire)  w_held  <= 1'b1;
        if (bvalid_q && bready) bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gcd_axil_rport.sv
module gcd_axil_rport #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic              rready,
  output logic [ADDR_W-1:0] look_addr,
  input  logic [DATA_W-1:0] look_data
);
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign arready   = !rvalid_q;
  assign look_addr = araddr;
  assign rvalid    = rvalid_q;
  assign rdata     = rdata_q;

  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid && arready) begin
      rvalid_q <= 1'b1;
      rdata_q  <= look_data;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/gcd_engine.sv
module gcd_engine
  import gcd_axil_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic              launch,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  eng_state_t        state;
  logic [DATA_W-1:0] x, y;
  logic              settle;

  assign busy   = (state == ENG_RUN);
  // zero on either side, or equal values, ends the loop; x|y then holds the answer
  assign settle = (x == '0) || (y == '0) || (x == y);

  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      state  <= ENG_IDLE;
      x      <= '0;
      y      <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ENG_IDLE: if (launch) begin
          x     <= opa;
          y     <= opb;
          state <= ENG_RUN;
        end
        ENG_RUN: begin
          if (settle) begin
            result <= x | y;
            done   <= 1'b1;
            state  <= ENG_IDLE;
          end else if (x > y) begin
            x <= x - y;
          end else begin
            y <= y - x;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gcd_axil_accel.sv
module gcd_axil_accel
  import gcd_axil_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8,
  localparam int WIN_LSB = 4
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic [ADDR_W-1:0] s_axil_awaddr,
  input  logic              s_axil_awvalid,
  output logic              s_axil_awready,
  input  logic [DATA_W-1:0] s_axil_wdata,
  input  logic [STRB_W-1:0] s_axil_wstrb,
  input  logic              s_axil_wvalid,
  output logic              s_axil_wready,
  output logic [1:0]        s_axil_bresp,
  output logic              s_axil_bvalid,
  input  logic              s_axil_bready,
  input  logic [ADDR_W-1:0] s_axil_araddr,
  input  logic              s_axil_arvalid,
  output logic              s_axil_arready,
  output logic [DATA_W-1:0] s_axil_rdata,
  output logic [1:0]        s_axil_rresp,
  output logic              s_axil_rvalid,
  input  logic              s_axil_rready
);
  logic              cmt_en;
  logic [ADDR_W-1:0] cmt_addr, look_addr;
  logic [DATA_W-1:0] cmt_data, look_data;
  logic [STRB_W-1:0] cmt_strb;

  logic [DATA_W-1:0] op_a, op_b, res_q, eng_result;
  logic              start_q, ready_q, eng_busy, eng_done;

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return ((a >> WIN_LSB) == '0) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                             input logic [DATA_W-1:0] new_v,
                                             input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int i = 0; i < STRB_W; i++)
      if (strb[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
    return r;
  endfunction

  gcd_axil_wport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wport (
    .aclk, .aresetn,
    .awaddr(s_axil_awaddr), .awvalid(s_axil_awvalid), .awready(s_axil_awready),
    .wdata(s_axil_wdata), .wstrb(s_axil_wstrb), .wvalid(s_axil_wvalid),
    .wready(s_axil_wready), .bvalid(s_axil_bvalid), .bready(s_axil_bready),
    .cmt_en, .cmt_addr, .cmt_data, .cmt_strb
  );

  gcd_axil_rport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rport (
    .aclk, .aresetn,
    .araddr(s_axil_araddr), .arvalid(s_axil_arvalid), .arready(s_axil_arready),
    .rdata(s_axil_rdata), .rvalid(s_axil_rvalid), .rready(s_axil_rready),
    .look_addr, .look_data
  );

  gcd_engine #(.DATA_W(DATA_W)) u_engine (
    .aclk, .aresetn,
    .launch(start_q), .opa(op_a), .opb(op_b),
    .busy(eng_busy), .done(eng_done), .result(eng_result)
  );

  assign s_axil_bresp = RESP_OKAY;
  assign s_axil_rresp = RESP_OKAY;

  // register file
  always_ff @(posedge aclk) begin
    if (!aresetn) begin
      op_a    <= '0;
      op_b    <= '0;
      res_q   <= '0;
      start_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (cmt_en && hit(cmt_addr)) begin
        unique case (cmt_addr[3:2])
          IDX_OPA: op_a <= merge(op_a, cmt_data, cmt_strb);
          IDX_OPB: op_b <= merge(op_b, cmt_data, cmt_strb);
          IDX_CTRL: if (cmt_strb[0] && cmt_data[CTRL_LAUNCH_BIT] && !eng_busy && !start_q)
            start_q <= 1'b1;
          default: ;
        endcase
      end
      if (start_q) ready_q <= 1'b0;
      else if (eng_done) begin
        ready_q <= 1'b1;
        res_q   <= eng_result;
      end
    end
  end

  always_comb begin
    look_data = '0;
    if (hit(look_addr)) begin
      unique case (look_addr[3:2])
        IDX_CTRL: begin
          look_data[CTRL_LAUNCH_BIT] = start_q;
          look_data[CTRL_DONE_BIT]   = ready_q;
        end
        IDX_OPA: look_data = op_a;
        IDX_OPB: look_data = op_b;
        IDX_RES: look_data = res_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gcd_axil_accel_chk.sv
module gcd_axil_accel_chk #(
  parameter int DATA_W = 32
) (
  input logic              aclk,
  input logic              aresetn,
  input logic              s_axil_awready,
  input logic              s_axil_wready,
  input logic              s_axil_bvalid,
  input logic              s_axil_bready,
  input logic [1:0]        s_axil_bresp,
  input logic              s_axil_arready,
  input logic              s_axil_rvalid,
  input logic              s_axil_rready,
  input logic [1:0]        s_axil_rresp,
  input logic [DATA_W-1:0] s_axil_rdata,
  input logic              start_q,
  input logic              ready_q,
  input logic              eng_busy
);
  assert_reset_clears_R1: assert property (@(posedge aclk)
    !aresetn |=> (!s_axil_bvalid && !s_axil_rvalid));

  assert_launch_pulse_R3: assert property (@(posedge aclk) disable iff (!aresetn)
    start_q |=> !start_q);

  assert_launch_idle_engine_R9: assert property (@(posedge aclk) disable iff (!aresetn)
    start_q |-> !eng_busy);

  assert_done_cleared_R4: assert property (@(posedge aclk) disable iff (!aresetn)
    start_q |=> (!ready_q && eng_busy));

  assert_okay_resp_R6: assert property (@(posedge aclk) disable iff (!aresetn)
    (s_axil_bvalid |-> s_axil_bresp == 2'b00) and (s_axil_rvalid |-> s_axil_rresp == 2'b00));

  assert_bvalid_hold_R8: assert property (@(posedge aclk) disable iff (!aresetn)
    (s_axil_bvalid && !s_axil_bready) |=> s_axil_bvalid);

  assert_rdata_hold_R8: assert property (@(posedge aclk) disable iff (!aresetn)
    (s_axil_rvalid && !s_axil_rready) |=> (s_axil_rvalid && $stable(s_axil_rdata)));

  assert_write_blocked_R8: assert property (@(posedge aclk) disable iff (!aresetn)
    s_axil_bvalid |-> (!s_axil_awready && !s_axil_wready));

  assert_read_blocked_R8: assert property (@(posedge aclk) disable iff (!aresetn)
    s_axil_rvalid |-> !s_axil_arready);
endmodule

bind gcd_axil_accel gcd_axil_accel_chk #(.DATA_W(DATA_W)) u_chk (
  .aclk, .aresetn,
  .s_axil_awready, .s_axil_wready, .s_axil_bvalid, .s_axil_bready, .s_axil_bresp,
  .s_axil_arready, .s_axil_rvalid, .s_axil_rready, .s_axil_rresp, .s_axil_rdata,
  .start_q, .ready_q, .eng_busy
);

// File: tb/gcd_axil_accel_test.sv
`timescale 1ns/1ps
module gcd_axil_accel_test;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          aclk = 1'b0;
  logic          aresetn = 1'b0;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic          awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [3:0]    wstrb = '0;
  logic          bready = 1'b1, rready = 1'b1;
  logic          awready, wready, bvalid, arready, rvalid;
  logic [1:0]    bresp, rresp;
  logic [DW-1:0] rdata;

  always #2 aclk = ~aclk;

  gcd_axil_accel uut (
    .aclk, .aresetn,
    .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
    .s_axil_wdata(wdata), .s_axil_wstrb(wstrb), .s_axil_wvalid(wvalid),
    .s_axil_wready(wready), .s_axil_bresp(bresp), .s_axil_bvalid(bvalid),
    .s_axil_bready(bready), .s_axil_araddr(araddr), .s_axil_arvalid(arvalid),
    .s_axil_arready(arready), .s_axil_rdata(rdata), .s_axil_rresp(rresp),
    .s_axil_rvalid(rvalid), .s_axil_rready(rready)
  );

  typedef struct { bit chk; logic [DW-1:0] exp; string req; } rexp_t;
  rexp_t rq[$];
  int    bq_n = 0;
  int    n_chk = 0, n_fail = 0;
  int    rd_sent = 0, rd_done = 0, wr_sent = 0, wr_done = 0;
  int    cyc = 0;
  logic [DW-1:0] last_rdata = '0;

  localparam logic [AW-1:0] A_CTRL = 32'h00, A_OPA = 32'h04, A_OPB = 32'h08, A_RES = 32'h0C;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  // monitor: pops scoreboard entries as responses leave the design
  always @(negedge aclk) begin
    if (aresetn) begin
      if (rvalid && rready) begin
        if (rq.size() == 0) check(1'b0, "R8 unexpected read response", rdata, '0);
        else begin
          rexp_t it;
          it = rq.pop_front();
          if (it.chk) check(rdata == it.exp, it.req, rdata, it.exp);
          check(rresp == 2'b00, "R6 rresp okay", {30'b0, rresp}, '0);
        end
        last_rdata = rdata;
        rd_done++;
      end
      if (bvalid && bready) begin
        if (bq_n == 0) check(1'b0, "R6 unexpected write response", '0, '0);
        else bq_n--;
        check(bresp == 2'b00, "R6 bresp okay", {30'b0, bresp}, '0);
        wr_done++;
      end
    end
  end

  always @(posedge aclk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog (all requirements)", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic send_aw(input logic [AW-1:0] a);
    bit hs;
    @(negedge aclk);
    awaddr = a; awvalid = 1'b1;
    forever begin
      hs = awready;
      @(posedge aclk);
      if (hs) break;
      @(negedge aclk);
    end
    #1 awvalid = 1'b0;
  endtask

  task automatic send_w(input logic [DW-1:0] d, input logic [3:0] s);
    bit hs;
    @(negedge aclk);
    wdata = d; wstrb = s; wvalid = 1'b1;
    forever begin
      hs = wready;
      @(posedge aclk);
      if (hs) break;
      @(negedge aclk);
    end
    #1 wvalid = 1'b0;
  endtask

  task automatic send_ar(input logic [AW-1:0] a);
    bit hs;
    @(negedge aclk);
    araddr = a; arvalid = 1'b1;
    forever begin
      hs = arready;
      @(posedge aclk);
      if (hs) break;
      @(negedge aclk);
    end
    #1 arvalid = 1'b0;
  endtask

  // order: 0 address then data, 1 data then address, 2 same cycle
  task automatic wr_issue(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [3:0] s, input int order);
    wr_sent++;
    bq_n++;
    if (order == 0) begin send_aw(a); send_w(d, s); end
    else if (order == 1) begin
      send_w(d, s);
      @(negedge aclk);
      check(!bvalid, "R6 no response before address", {31'b0, bvalid}, '0);
      send_aw(a);
    end else fork send_aw(a); send_w(d, s); join
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [3:0] s, input int order);
    int tgt;
    tgt = wr_sent + 1;
    wr_issue(a, d, s, order);
    while (wr_done < tgt) @(negedge aclk);
  endtask

  task automatic rd_issue(input logic [AW-1:0] a, input bit c, input logic [DW-1:0] e,
                          input string r);
    rd_sent++;
    rq.push_back('{c, e, r});
    send_ar(a);
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit c, input logic [DW-1:0] e,
                    input string r);
    int tgt;
    tgt = rd_sent + 1;
    rd_issue(a, c, e, r);
    while (rd_done < tgt) @(negedge aclk);
  endtask

  task automatic poll_done(input string r);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      rd(A_CTRL, 1'b0, '0, r);
      if (last_rdata[1]) begin seen = 1'b1; break; end
    end
    check(seen, r, {31'b0, seen}, 1);
  endtask

  initial begin
    repeat (5) @(posedge aclk);
    @(negedge aclk) aresetn = 1'b1;
    @(negedge aclk);
    check(!bvalid && !rvalid, "R1 no responses after reset", {bvalid, rvalid}, '0);
    check(awready && wready && arready, "R1 readies after reset",
          {awready, wready, arready}, 3'b111);
    rd(A_CTRL, 1'b1, '0, "R1 ctrl resets to 0");
    rd(A_OPA,  1'b1, '0, "R1 A resets to 0");
    rd(A_OPB,  1'b1, '0, "R1 B resets to 0");
    rd(A_RES,  1'b1, '0, "R1 R resets to 0");

    // R2 operands and byte strobes
    wr(A_OPA, 32'h11223344, 4'hF, 0);
    wr(A_OPA, 32'hAABBCCDD, 4'b0011, 1);
    rd(A_OPA, 1'b1, 32'h1122CCDD, "R2 A with lane strobes");
    wr(A_OPB, 32'hCAFEF00D, 4'hF, 2);
    rd(A_OPB, 1'b1, 32'hCAFEF00D, "R2 B readback");

    // R3 two reference computations, read within 20 cycles of launch
    wr(A_OPA, 35, 4'hF, 0);
    wr(A_OPB, 25, 4'hF, 0);
    wr(A_CTRL, 1, 4'hF, 0);
    repeat (14) @(negedge aclk);
    rd(A_CTRL, 1'b1, 32'h2, "R3 done bit set, launch bit clear");
    rd(A_RES, 1'b1, 5, "R3 gcd(35,25)");
    wr(A_OPA, 128, 4'hF, 1);
    wr(A_OPB, 72, 4'hF, 2);
    wr(A_CTRL, 1, 4'hF, 0);
    repeat (14) @(negedge aclk);
    rd(A_RES, 1'b1, 8, "R3 gcd(128,72)");

    // R4 + R9 long run with operand writes and a second launch mid-flight
    wr(A_OPA, 1000, 4'hF, 0);
    wr(A_OPB, 10, 4'hF, 0);
    wr(A_CTRL, 1, 4'hF, 0);
    rd(A_CTRL, 1'b1, 32'h0, "R4 done bit cleared by launch");
    wr(A_OPA, 77, 4'hF, 2);
    wr(A_CTRL, 1, 4'hF, 1);
    rd(A_OPA, 1'b1, 77, "R9 A stored during run");
    poll_done("R9 run completes");
    rd(A_RES, 1'b1, 10, "R9 result unaffected by mid-run writes");

    // R5 zero operands
    wr(A_OPA, 0, 4'hF, 0);
    wr(A_OPB, 9, 4'hF, 0);
    wr(A_CTRL, 1, 4'hF, 0);
    repeat (4) @(negedge aclk);
    rd(A_RES, 1'b1, 9, "R5 gcd(0,9)");
    wr(A_OPA, 12, 4'hF, 0);
    wr(A_OPB, 0, 4'hF, 0);
    wr(A_CTRL, 1, 4'hF, 0);
    repeat (4) @(negedge aclk);
    rd(A_RES, 1'b1, 12, "R5 gcd(12,0)");
    wr(A_OPA, 0, 4'hF, 0);
    wr(A_CTRL, 1, 4'hF, 0);
    repeat (4) @(negedge aclk);
    rd(A_CTRL, 1'b1, 32'h2, "R5 gcd(0,0) done");
    rd(A_RES, 1'b1, 0, "R5 gcd(0,0)");

    // R7 unmapped offsets
    wr(A_OPA, 32'h5A5A0001, 4'hF, 0);
    wr(32'h10, 32'hFFFFFFFF, 4'hF, 0);
    wr(32'h05, 32'h0, 4'hF, 2);
    wr(32'h104, 32'h0, 4'hF, 1);
    rd(32'h10, 1'b1, 0, "R7 offset 0x10 reads 0");
    rd(32'h06, 1'b1, 0, "R7 unaligned reads 0");
    rd(A_OPA, 1'b1, 32'h5A5A0001, "R7 A untouched by unmapped writes");

    // R8 back-pressure on both responses
    bready = 1'b0;
    wr_issue(A_OPB, 32'h00000033, 4'hF, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge aclk);
      check(bvalid && !awready && !wready, "R8 write response held, channel blocked",
            {bvalid, awready, wready}, 3'b100);
    end
    bready = 1'b1;
    while (wr_done < wr_sent) @(negedge aclk);
    rready = 1'b0;
    rd_issue(A_OPB, 1'b1, 32'h33, "R8 held read data");
    for (int i = 0; i < 3; i++) begin
      @(negedge aclk);
      check(rvalid && !arready && rdata == 32'h33, "R8 read response held", rdata, 32'h33);
    end
    rready = 1'b1;
    while (rd_done < rd_sent) @(negedge aclk);

    repeat (4) @(negedge aclk);
    check(rq.size() == 0 && bq_n == 0, "R6 scoreboard drained", rq.size() + bq_n, 0);
    summary();
    $finish;
  end
endmodule